// File: doc/BRIEF.md
# Five-Phase Instruction Sequencer and Control Decoder

This block drives a non-pipelined datapath for a 32-bit integer instruction subset: register and immediate arithmetic, logic, shifts, set-less-than, word load, word store and branch-if-equal. Every instruction spends exactly five clock cycles in the block, stepping through fetch, decode, execute, memory and writeback phases. The sequence does not shorten for branches, stores or unknown encodings.

From the instruction word and the ALU zero flag, the block produces the datapath control. This covers the 4-bit ALU operation, the operand-2 immediate select, the writeback source select, the register-file write enable, the data-memory read and write strobes, the PC load enable and the PC branch-target select. The selects come from the instruction alone and do not depend on the phase. The strobes and enables are asserted only in their own phase. The current phase is also brought out for debug.

Top module: `seq_ctrl_unit`

## Requirements
- R1: After each rising clock edge with reset low, `phase` advances 0 (fetch) → 1 (decode) → 2 (execute) → 3 (memory) → 4 (writeback) → 0, so every instruction occupies exactly five cycles.
- R2: A rising edge with `rst` high forces `phase` to 0, including from the middle of an instruction.
- R3: `alu_op` uses these codes: AND 0000, OR 0001, ADD 0010, SUB 0110, SLT 0111, SRL 1000, SLL 1001, SRA 1010, XOR 1101. Load (opcode 0000011) and store (opcode 0100011) give ADD. Branch (opcode 1100011) gives SUB. Register (0110011) and immediate (0010011) ALU instructions decode funct3 (bits 14:12) as 000 add, 001 sll, 010 slt, 100 xor, 101 right shift, 110 or, 111 and.
- R4: Instruction bit 30 selects SUB over ADD only for register-register instructions; an add-immediate with bit 30 set stays ADD. Bit 30 selects SRA over SRL for both the register and the immediate right shift.
- R5: `op2_imm` is 1 for the load, store and immediate-ALU opcodes and 0 for every other opcode, in every phase.
- R6: `dmem_rd` is 1 only in phase 3 and only for a load. `dmem_wr` is 1 only in phase 3 and only for a store. The two are never high together.
- R7: `rf_we` is 1 only in phase 4, and only for the load, register-ALU and immediate-ALU opcodes. It stays 0 in all five cycles of a store or a branch.
- R8: `wb_from_mem` is 1 for a load in every phase and 0 for every other instruction.
- R9: `pc_load` is 1 in phase 4 for every instruction, including unknown ones, and 0 in all other phases.
- R10: `pc_branch` is 1, in any phase, exactly when the opcode is 1100011, funct3 is 000 and `alu_zero` is 1. Otherwise it is 0.
- R11: An unrecognised opcode still takes five cycles. For such an opcode `rf_we`, `dmem_rd`, `dmem_wr`, `pc_branch`, `op2_imm` and `wb_from_mem` all stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word currently held by the datapath |
| alu_zero | input | 1 | ALU result-equals-zero flag |
| alu_op | output | 4 | ALU operation code |
| op2_imm | output | 1 | 1 selects the immediate as ALU operand 2, 0 selects the second register |
| wb_from_mem | output | 1 | 1 selects memory read data for writeback |
| rf_we | output | 1 | Register-file write enable |
| dmem_rd | output | 1 | Data-memory read strobe |
| dmem_wr | output | 1 | Data-memory write strobe |
| pc_load | output | 1 | PC update enable |
| pc_branch | output | 1 | 1 selects the branch target for the next PC, 0 selects PC+4 |
| phase | output | 3 | Current phase, for debug |

## Verification
The assertions assume that `rst` is high at the first clock edge, so that `phase` begins from a known value. They also assume that the datapath presents `alu_zero` as a level and not as a pulse synchronised to a phase. The stimulus holds reset for two edges at start-up. It changes `instr` and `alu_zero` only shortly after a rising edge and keeps them fixed for the whole five-cycle instruction. It drives `alu_zero` high during non-branch instructions, to show that the flag alone never raises `pc_branch`.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 7;
    localparam int F3_W     = 3;
    localparam int ALU_OP_W = 4;
    localparam int PHASE_W  = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_MEM    = 3'd3,
        PH_WB     = 3'd4
    } phase_t;

    typedef enum logic [ALU_OP_W-1:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_SRL = 4'b1000,
        ALU_SLL = 4'b1001,
        ALU_SRA = 4'b1010,
        ALU_XOR = 4'b1101
    } alu_op_t;

    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_ALUIMM = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_ALUREG = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;

    localparam logic [F3_W-1:0] F3_ADD = 3'b000;
    localparam logic [F3_W-1:0] F3_SLL = 3'b001;
    localparam logic [F3_W-1:0] F3_SLT = 3'b010;
    localparam logic [F3_W-1:0] F3_XOR = 3'b100;
    localparam logic [F3_W-1:0] F3_SHR = 3'b101;
    localparam logic [F3_W-1:0] F3_OR  = 3'b110;
    localparam logic [F3_W-1:0] F3_AND = 3'b111;
    localparam logic [F3_W-1:0] F3_BEQ = 3'b000;

    typedef struct packed {
        logic is_load;
        logic is_store;
        logic is_aluimm;
        logic is_alureg;
        logic is_branch;
        logic is_beq;
    } instr_class_t;

    function automatic phase_t phase_after(input phase_t cur);
        case (cur)
            PH_FETCH:  return PH_DECODE;
            PH_DECODE: return PH_EXEC;
            PH_EXEC:   return PH_MEM;
            PH_MEM:    return PH_WB;
            default:   return PH_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/ctrl_phase_seq.sv
module ctrl_phase_seq
    import ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_after(phase_q);
        end
    end

endmodule

// File: rtl/ctrl_instr_class.sv
module ctrl_instr_class
    import ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [F3_W-1:0]  funct3,
    output instr_class_t     cls
);

    always_comb begin
        cls           = '0;
        cls.is_load   = (opcode == OPC_LOAD);
        cls.is_store  = (opcode == OPC_STORE);
        cls.is_aluimm = (opcode == OPC_ALUIMM);
        cls.is_alureg = (opcode == OPC_ALUREG);
        cls.is_branch = (opcode == OPC_BRANCH);
        cls.is_beq    = (opcode == OPC_BRANCH) && (funct3 == F3_BEQ);
    end

endmodule

// File: rtl/ctrl_alu_sel.sv
module ctrl_alu_sel
    import ctrl_pkg::*;
(
    input  instr_class_t    cls,
    input  logic [F3_W-1:0] funct3,
    input  logic            alt_bit,
    output alu_op_t         op
);

    alu_op_t arith_op;

    always_comb begin
        case (funct3)
            F3_ADD:  arith_op = (cls.is_alureg && alt_bit) ? ALU_SUB : ALU_ADD;
            F3_SLL:  arith_op = ALU_SLL;
            F3_SLT:  arith_op = ALU_SLT;
            F3_XOR:  arith_op = ALU_XOR;
            F3_SHR:  arith_op = alt_bit ? ALU_SRA : ALU_SRL;
            F3_OR:   arith_op = ALU_OR;
            F3_AND:  arith_op = ALU_AND;
            default: arith_op = ALU_ADD;
        endcase
    end

    always_comb begin
        if (cls.is_branch) begin
            op = ALU_SUB;
        end else if (cls.is_alureg || cls.is_aluimm) begin
            op = arith_op;
        end else begin
            op = ALU_ADD;
        end
    end

endmodule

// File: rtl/seq_ctrl_unit.sv
module seq_ctrl_unit
    import ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  instr,
    input  logic                alu_zero,
    output logic [ALU_OP_W-1:0] alu_op,
    output logic                op2_imm,
    output logic                wb_from_mem,
    output logic                rf_we,
    output logic                dmem_rd,
    output logic                dmem_wr,
    output logic                pc_load,
    output logic                pc_branch,
    output logic [PHASE_W-1:0]  phase
);

    localparam int F3_LSB  = 12;
    localparam int ALT_BIT = 30;

    phase_t       phase_q;
    instr_class_t cls;
    alu_op_t      op_sel;
    logic         writes_rd;
    logic         unused_instr_bits;

    assign unused_instr_bits = ^{instr[31], instr[29:15], instr[11:7]};

    ctrl_phase_seq i_seq (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q)
    );

    ctrl_instr_class i_class (
        .opcode (instr[OPC_W-1:0]),
        .funct3 (instr[F3_LSB +: F3_W]),
        .cls    (cls)
    );

    ctrl_alu_sel i_alu_sel (
        .cls     (cls),
        .funct3  (instr[F3_LSB +: F3_W]),
        .alt_bit (instr[ALT_BIT]),
        .op      (op_sel)
    );

    assign writes_rd = cls.is_load | cls.is_aluimm | cls.is_alureg;

    always_comb begin
        alu_op      = op_sel;
        op2_imm     = cls.is_load | cls.is_store | cls.is_aluimm;
        wb_from_mem = cls.is_load;
        pc_branch   = cls.is_beq & alu_zero;
        rf_we       = (phase_q == PH_WB) & writes_rd;
        dmem_rd     = (phase_q == PH_MEM) & cls.is_load;
        dmem_wr     = (phase_q == PH_MEM) & cls.is_store;
        pc_load     = (phase_q == PH_WB);
        phase       = phase_q;
    end

endmodule

// File: rtl/seq_ctrl_unit_chk.sv
module seq_ctrl_unit_chk
    import ctrl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               alu_zero,
    input logic               rf_we,
    input logic               dmem_rd,
    input logic               dmem_wr,
    input logic               pc_load,
    input logic               pc_branch,
    input logic [PHASE_W-1:0] phase
);

    localparam logic [PHASE_W-1:0] P_FETCH = 3'd0;
    localparam logic [PHASE_W-1:0] P_MEM   = 3'd3;
    localparam logic [PHASE_W-1:0] P_WB    = 3'd4;

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
        (phase != P_WB) |=> (phase == $past(phase) + 3'd1));

    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == P_WB) |=> (phase == P_FETCH));

    assert_reset_fetch_R2: assert property (@(posedge clk)
        rst |=> (phase == P_FETCH));

    assert_mem_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (dmem_rd || dmem_wr) |-> (phase == P_MEM));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd && dmem_wr));

    assert_we_gate_R7: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (phase == P_WB));

    assert_pc_load_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == P_WB) |-> pc_load);

    assert_pc_load_only_wb_R9: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (phase == P_WB));

    assert_branch_zero_R10: assert property (@(posedge clk) disable iff (rst)
        pc_branch |-> alu_zero);

endmodule

bind seq_ctrl_unit seq_ctrl_unit_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .alu_zero  (alu_zero),
    .rf_we     (rf_we),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .pc_load   (pc_load),
    .pc_branch (pc_branch),
    .phase     (phase)
);

// File: tb/test_seq_ctrl_unit.sv
module test_seq_ctrl_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic        alu_zero = 1'b0;
    logic [3:0]  alu_op;
    logic        op2_imm, wb_from_mem, rf_we, dmem_rd, dmem_wr, pc_load, pc_branch;
    logic [2:0]  phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] ph;
        logic [3:0] alu;
        bit         chk_alu;
        logic       imm, m2r, we, rd, wr, pcl, br;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_ctrl_unit i_seq_ctrl_unit (
        .clk(clk), .rst(rst), .instr(instr), .alu_zero(alu_zero),
        .alu_op(alu_op), .op2_imm(op2_imm), .wb_from_mem(wb_from_mem),
        .rf_we(rf_we), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .pc_load(pc_load), .pc_branch(pc_branch), .phase(phase)
    );

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3);
        return {f7, 5'd3, 5'd2, f3, 5'd1, 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3,
                                          input logic [6:0] opc);
        return {imm, 5'd2, f3, 5'd1, opc};
    endfunction

    function automatic logic [31:0] enc_b(input logic [2:0] f3);
        return {7'd0, 5'd3, 5'd2, f3, 5'd8, 7'b1100011};
    endfunction

    task automatic bad(input string what, input int act, input int exp);
        $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    endtask

    // Driver: hold one instruction for five cycles, queue the expected outputs per phase.
    task automatic run_instr(input logic [31:0] word, input logic z, input string tag,
                             input bit chk_alu, input logic [3:0] alu,
                             input logic imm, input logic m2r, input logic wrd,
                             input logic ld, input logic st, input logic br);
        for (int p = 0; p < 5; p++) begin
            exp_t e;
            instr    = word;
            alu_zero = z;
            e.ph      = 3'(p);
            e.alu     = alu;
            e.chk_alu = chk_alu;
            e.imm     = imm;
            e.m2r     = m2r;
            e.we      = wrd & (p == 4);
            e.rd      = ld & (p == 3);
            e.wr      = st & (p == 3);
            e.pcl     = (p == 4);
            e.br      = br;
            e.tag     = tag;
            sb.push_back(e);
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            bit   ok;
            e  = sb.pop_front();
            ok = 1'b1;
            checks++;
            if (phase !== e.ph) begin ok = 0; bad({e.tag, " R1 phase"}, phase, e.ph); end
            if (e.chk_alu && alu_op !== e.alu) begin ok = 0; bad({e.tag, " R3/R4 alu_op"}, alu_op, e.alu); end
            if (op2_imm !== e.imm) begin ok = 0; bad({e.tag, " R5 op2_imm"}, op2_imm, e.imm); end
            if (dmem_rd !== e.rd) begin ok = 0; bad({e.tag, " R6 dmem_rd"}, dmem_rd, e.rd); end
            if (dmem_wr !== e.wr) begin ok = 0; bad({e.tag, " R6 dmem_wr"}, dmem_wr, e.wr); end
            if (rf_we !== e.we) begin ok = 0; bad({e.tag, " R7 rf_we"}, rf_we, e.we); end
            if (wb_from_mem !== e.m2r) begin ok = 0; bad({e.tag, " R8 wb_from_mem"}, wb_from_mem, e.m2r); end
            if (pc_load !== e.pcl) begin ok = 0; bad({e.tag, " R9 pc_load"}, pc_load, e.pcl); end
            if (pc_branch !== e.br) begin ok = 0; bad({e.tag, " R10 pc_branch"}, pc_branch, e.br); end
            if (!ok) fails++;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        // R2 reset state
        checks++;
        if (phase !== 3'd0 || rf_we !== 1'b0 || pc_load !== 1'b0) begin
            fails++;
            bad("R2 reset phase", phase, 0);
        end

        // R3 / R4: register-register ALU
        run_instr(enc_r(7'h00, 3'b000), 1'b1, "add R3", 1, 4'b0010, 0, 0, 1, 0, 0, 0);
        run_instr(enc_r(7'h20, 3'b000), 1'b1, "sub R4", 1, 4'b0110, 0, 0, 1, 0, 0, 0);
        run_instr(enc_r(7'h00, 3'b010), 1'b0, "slt R3", 1, 4'b0111, 0, 0, 1, 0, 0, 0);
        run_instr(enc_r(7'h00, 3'b001), 1'b0, "sll R3", 1, 4'b1001, 0, 0, 1, 0, 0, 0);
        run_instr(enc_r(7'h00, 3'b101), 1'b0, "srl R4", 1, 4'b1000, 0, 0, 1, 0, 0, 0);
        run_instr(enc_r(7'h20, 3'b101), 1'b0, "sra R4", 1, 4'b1010, 0, 0, 1, 0, 0, 0);
        run_instr(enc_r(7'h00, 3'b111), 1'b1, "and R3", 1, 4'b0000, 0, 0, 1, 0, 0, 0);
        run_instr(enc_r(7'h00, 3'b110), 1'b0, "or R3",  1, 4'b0001, 0, 0, 1, 0, 0, 0);
        run_instr(enc_r(7'h00, 3'b100), 1'b0, "xor R3", 1, 4'b1101, 0, 0, 1, 0, 0, 0);

        // R4 / R5: immediate ALU, addi with bit 30 set must stay ADD
        run_instr(enc_i(12'h400, 3'b000, 7'b0010011), 1'b1, "addi-b30 R4", 1, 4'b0010, 1, 0, 1, 0, 0, 0);
        run_instr(enc_i(12'h005, 3'b010, 7'b0010011), 1'b0, "slti R3",  1, 4'b0111, 1, 0, 1, 0, 0, 0);
        run_instr(enc_i(12'h003, 3'b001, 7'b0010011), 1'b0, "slli R3",  1, 4'b1001, 1, 0, 1, 0, 0, 0);
        run_instr(enc_i(12'h003, 3'b101, 7'b0010011), 1'b0, "srli R4",  1, 4'b1000, 1, 0, 1, 0, 0, 0);
        run_instr(enc_i(12'h403, 3'b101, 7'b0010011), 1'b0, "srai R4",  1, 4'b1010, 1, 0, 1, 0, 0, 0);
        run_instr(enc_i(12'h0ff, 3'b111, 7'b0010011), 1'b0, "andi R3",  1, 4'b0000, 1, 0, 1, 0, 0, 0);
        run_instr(enc_i(12'h0ff, 3'b110, 7'b0010011), 1'b0, "ori R3",   1, 4'b0001, 1, 0, 1, 0, 0, 0);
        run_instr(enc_i(12'h0ff, 3'b100, 7'b0010011), 1'b0, "xori R3",  1, 4'b1101, 1, 0, 1, 0, 0, 0);

        // R6 / R8: memory
        run_instr(enc_i(12'h004, 3'b010, 7'b0000011), 1'b1, "lw R6 R8", 1, 4'b0010, 1, 1, 1, 1, 0, 0);
        run_instr({7'd0, 5'd3, 5'd2, 3'b010, 5'd4, 7'b0100011}, 1'b1, "sw R6 R7", 1, 4'b0010, 1, 0, 0, 0, 1, 0);

        // R10: branches
        run_instr(enc_b(3'b000), 1'b1, "beq-taken R10",    1, 4'b0110, 0, 0, 0, 0, 0, 1);
        run_instr(enc_b(3'b000), 1'b0, "beq-nottaken R10", 1, 4'b0110, 0, 0, 0, 0, 0, 0);
        run_instr(enc_b(3'b001), 1'b1, "bne-form R10",     0, 4'b0000, 0, 0, 0, 0, 0, 0);

        // R11: unknown opcode
        run_instr(32'hffff_ffff, 1'b1, "unknown R11", 0, 4'b0000, 0, 0, 0, 0, 0, 0);
        run_instr(enc_i(12'h0, 3'b0, 7'b1110011), 1'b1, "system R11", 0, 4'b0000, 0, 0, 0, 0, 0, 0);

        // R2: reset in the middle of an instruction
        for (int p = 0; p < 2; p++) begin
            exp_t e;
            instr = enc_r(7'h00, 3'b000);
            alu_zero = 1'b0;
            e.ph = 3'(p); e.alu = 4'b0010; e.chk_alu = 1; e.imm = 0; e.m2r = 0;
            e.we = 0; e.rd = 0; e.wr = 0; e.pcl = 0; e.br = 0; e.tag = "pre-reset R2";
            sb.push_back(e);
            @(posedge clk);
            #1;
        end
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        checks++;
        if (phase !== 3'd0) begin
            fails++;
            bad("R2 mid-instruction reset phase", phase, 0);
        end
        run_instr(enc_r(7'h00, 3'b000), 1'b0, "after-reset R1", 1, 4'b0010, 0, 0, 1, 0, 0, 0);

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule